// File: doc/BRIEF.md
# Suspend Wake and Serial Power Controller

This block sits between a bus suspend indication and the serial port of a bus-to-serial bridge. While the bus is suspended it watches the five serial input lines: receive data, data set ready, ring indicator, carrier detect and clear to send. When a line chosen in the configuration word changes level, the block raises a wake request. The request is qualified as either a resume request or a disconnect request.

The same configuration word sets the suspend-time policy for the serial side. It decides whether the line transceiver is powered down and whether the serial outputs float. A strap pin, captured while reset is held, decides between two ways of quieting the outputs during suspend: they are either parked at their inactive levels or released to high impedance.

Top module: `susp_wake_ctrl`

## Requirements
- R1: Each serial line passes through two synchroniser flops before its edge detector. Both a rising and a falling change of an enabled line wake the block. The wake pulse is visible in the third clock cycle after the cycle in which the line changed, and `wake_req` is high for exactly one cycle.
- R2: The per-line wake enables are configuration bits 20, 19, 18, 17 and 16, for receive data, data set ready, ring indicator, carrier detect and clear to send respectively. A change on a line whose enable bit is 0 produces no wake.
- R3: Configuration bit 21 qualifies each wake. With bit 21 at 1, `wake_resume` pulses together with `wake_req`. With bit 21 at 0, `wake_disc` pulses together with `wake_req`. The two never pulse together.
- R4: While configuration bit 12 is 1, no wake request of any kind is issued.
- R5: Wake detection is armed only while `suspend` is high, and only from the fourth cycle of suspend onward. A line change applied in the same cycle that suspend rises is ignored. A change while `suspend` is low is also ignored.
- R6: At most one wake is issued per suspend episode. Later line changes stay silent until `suspend` falls and rises again.
- R7: With configuration bit 0 at 1, `xcvr_off` is high and `xcvr_off_n` is low while `suspend` is high. With bit 0 at 0, or when not suspended, `xcvr_off` is low and `xcvr_off_n` is high.
- R8: Configuration bit 22 at 1 drives `out_hiz` high at all times, suspended or not, and holds `out_idle` low.
- R9: The `strap_park` level is captured while reset is asserted. If it was high, suspend raises `out_idle` and leaves `out_hiz` low. If it was low, suspend raises `out_hiz`. Changing the strap after reset has no effect.
- R10: Directly after reset, with a zero configuration word and `suspend` low, every wake output is low, `xcvr_off` is low, `xcvr_off_n` is high, and both output controls are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_park | input | 1 | Suspend output policy strap, captured during reset |
| suspend | input | 1 | Bus suspend indication |
| line_rxd | input | 1 | Serial receive data line |
| line_dsr | input | 1 | Data set ready line |
| line_ri | input | 1 | Ring indicator line |
| line_dcd | input | 1 | Carrier detect line |
| line_cts | input | 1 | Clear to send line |
| cfg | input | 24 | Device configuration word |
| wake_req | output | 1 | One-cycle wake request pulse |
| wake_resume | output | 1 | Wake pulse qualified as a resume request |
| wake_disc | output | 1 | Wake pulse qualified as a disconnect request |
| xcvr_off | output | 1 | Serial transceiver shutdown |
| xcvr_off_n | output | 1 | Inverted companion of the shutdown output |
| out_hiz | output | 1 | Serial outputs to high impedance |
| out_idle | output | 1 | Serial outputs parked at inactive levels |

## Verification
A stale synchroniser or edge register shows up as a wake that arrives one cycle early or late, or as a missing wake on a falling edge. The bench checks the exact cycle of every pulse, so such a fault is caught on the first line change. A wrong arming count or a stuck "already woken" flag shows up as a wake from an entry-time edge, or as a second pulse within one suspend. The bench catches these within a few cycles, because it counts every pulse in a window. A badly captured strap changes `out_hiz` or `out_idle` in the first suspended cycle after reset.

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl #(
  parameter int CFG_W       = 24,
  parameter int NLINES      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int EN_LSB      = 16,
  parameter int MODE_BIT    = 21,
  parameter int INH_BIT     = 12,
  parameter int SHUT_BIT    = 0,
  parameter int HIZ_BIT     = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_park,
  input  logic             suspend,
  input  logic             line_rxd,
  input  logic             line_dsr,
  input  logic             line_ri,
  input  logic             line_dcd,
  input  logic             line_cts,
  input  logic [CFG_W-1:0] cfg,
  output logic             wake_req,
  output logic             wake_resume,
  output logic             wake_disc,
  output logic             xcvr_off,
  output logic             xcvr_off_n,
  output logic             out_hiz,
  output logic             out_idle
);

  localparam int ARM_DLY = SYNC_STAGES + 1;
  localparam int CW      = $clog2(ARM_DLY + 1);
  localparam logic [CW-1:0] ARM_MAX = CW'(ARM_DLY);

  logic [NLINES-1:0] lines_in;
  logic [NLINES-1:0] sync_q [SYNC_STAGES];
  logic [NLINES-1:0] last_q;
  logic [NLINES-1:0] changed;
  logic [CW-1:0]     arm_cnt;
  logic              armed;
  logic              fired;
  logic              strap_q;
  logic              trig;

  assign lines_in = {line_rxd, line_dsr, line_ri, line_dcd, line_cts};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= lines_in;
      else         sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign changed = sync_q[SYNC_STAGES-1] ^ last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              arm_cnt <= '0;
    else if (!suspend)       arm_cnt <= '0;
    else if (arm_cnt != ARM_MAX) arm_cnt <= arm_cnt + 1'b1;
  end

  assign armed = suspend && (arm_cnt == ARM_MAX);
  assign trig  = armed && !fired && !cfg[INH_BIT] &&
                 |(changed & cfg[EN_LSB +: NLINES]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fired <= 1'b0;
    else if (!suspend) fired <= 1'b0;
    else if (trig)     fired <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_req    <= 1'b0;
      wake_resume <= 1'b0;
      wake_disc   <= 1'b0;
    end else begin
      wake_req    <= trig;
      wake_resume <= trig &&  cfg[MODE_BIT];
      wake_disc   <= trig && !cfg[MODE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strap_q <= strap_park;
  end

  assign xcvr_off   = suspend & cfg[SHUT_BIT];
  assign xcvr_off_n = ~xcvr_off;
  assign out_hiz    = cfg[HIZ_BIT] | (suspend & ~strap_q);
  assign out_idle   = suspend & strap_q & ~cfg[HIZ_BIT];

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  a_r3_one_qualifier: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (wake_resume ^ wake_disc));
  a_r3_no_stray_qual: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_req |-> !(wake_resume || wake_disc));
  a_r4_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> !$past(cfg[INH_BIT]));
  a_r5_needs_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(suspend));
  a_r6_once_per_episode: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && suspend) |=> (suspend |-> !wake_req));
  a_r7_awake_powered: assert property (@(posedge clk) disable iff (!rst_n)
    !suspend |-> (!xcvr_off && xcvr_off_n));
  a_r9_exclusive_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hiz && out_idle));

endmodule

// File: tb/sim_susp_wake_ctrl.sv
module sim_susp_wake_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b1;
  logic susp = 1'b0;
  logic [4:0] ln = '0;
  logic [23:0] cfg = '0;
  logic wr, wres, wdis, xo, xon, hz, idl;
  int checks = 0;
  int fails = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  susp_wake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .strap_park(strap), .suspend(susp),
    .line_rxd(ln[4]), .line_dsr(ln[3]), .line_ri(ln[2]),
    .line_dcd(ln[1]), .line_cts(ln[0]), .cfg(cfg),
    .wake_req(wr), .wake_resume(wres), .wake_disc(wdis),
    .xcvr_off(xo), .xcvr_off_n(xon), .out_hiz(hz), .out_idle(idl)
  );

  always @(negedge clk) if (wr) pulses++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {en[4:0], rw, inh, idx[2:0], exp}
  localparam logic [10:0] VEC [8] = '{
    {5'b10000, 1'b1, 1'b0, 3'd4, 1'b1},
    {5'b01000, 1'b0, 1'b0, 3'd3, 1'b1},
    {5'b00100, 1'b1, 1'b0, 3'd2, 1'b1},
    {5'b00010, 1'b0, 1'b0, 3'd1, 1'b1},
    {5'b00001, 1'b1, 1'b0, 3'd0, 1'b1},
    {5'b11110, 1'b1, 1'b0, 3'd0, 1'b0},
    {5'b11111, 1'b0, 1'b1, 3'd2, 1'b0},
    {5'b00001, 1'b0, 1'b0, 3'd4, 1'b0}
  };

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R10 reset state
    chk(!wr && !wres && !wdis, "R10 wake idle", wr, 0);
    chk(!xo && xon, "R10 xcvr on", xo, 0);
    chk(!hz && !idl, "R10 out ctrls", hz + idl, 0);

    // R1 R2 R3 R4 vector walk
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      v = VEC[i];
      cfg = '0;
      cfg[20:16] = v[10:6];
      cfg[21] = v[5];
      cfg[12] = v[4];
      susp = 1'b1;
      cyc(6);
      p0 = pulses;
      ln[v[3:1]] = ~ln[v[3:1]];
      @(posedge clk); @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk(wr == v[0], "R1 R2 R4 wake timing", wr, v[0]);
      chk(wres == (v[0] & v[5]), "R3 resume qual", wres, v[0] & v[5]);
      chk(wdis == (v[0] & ~v[5]), "R3 disc qual", wdis, v[0] & ~v[5]);
      cyc(1);
      chk(!wr, "R1 one cycle", wr, 0);
      chk(pulses - p0 == int'(v[0]), "R2 R4 pulse count", pulses - p0, v[0]);
      susp = 1'b0;
      cyc(3);
    end

    // R1 falling edge and R6 no repeat
    cfg = '0; cfg[17] = 1'b1; cfg[21] = 1'b1;
    ln[1] = 1'b1;
    cyc(5);
    susp = 1'b1;
    cyc(6);
    p0 = pulses;
    ln[1] = 1'b0;
    cyc(5);
    chk(pulses - p0 == 1, "R1 falling edge wakes", pulses - p0, 1);
    ln[1] = 1'b1;
    cyc(6);
    ln[1] = 1'b0;
    cyc(6);
    chk(pulses - p0 == 1, "R6 no second wake", pulses - p0, 1);
    susp = 1'b0;
    cyc(3);
    susp = 1'b1;
    cyc(6);
    ln[1] = 1'b1;
    cyc(6);
    chk(pulses - p0 == 2, "R6 rearm after re-entry", pulses - p0, 2);
    susp = 1'b0;
    cyc(3);

    // R5 change while awake, and change at suspend entry
    p0 = pulses;
    ln[1] = ~ln[1];
    cyc(8);
    chk(pulses == p0, "R5 awake change ignored", pulses - p0, 0);
    susp = 1'b1;
    ln[1] = ~ln[1];
    cyc(10);
    chk(pulses == p0, "R5 entry edge ignored", pulses - p0, 0);
    ln[1] = ~ln[1];
    cyc(6);
    chk(pulses - p0 == 1, "R5 armed after entry", pulses - p0, 1);
    susp = 1'b0;
    cyc(2);

    // R7 shutdown
    cfg = '0; cfg[0] = 1'b1;
    cyc(1);
    chk(!xo && xon, "R7 awake powered", xo, 0);
    susp = 1'b1;
    cyc(1);
    chk(xo && !xon, "R7 suspended off", xo, 1);
    cfg[0] = 1'b0;
    cyc(1);
    chk(!xo && xon, "R7 bit0 clear keeps power", xo, 0);

    // R9 strap high parks, later strap change ignored
    chk(idl && !hz, "R9 strap high parks", idl, 1);
    strap = 1'b0;
    cyc(2);
    chk(idl && !hz, "R9 strap change after reset ignored", hz, 0);

    // R8 tri-state bit
    cfg[22] = 1'b1;
    cyc(1);
    chk(hz && !idl, "R8 forced hiz suspended", hz, 1);
    susp = 1'b0;
    cyc(1);
    chk(hz && !idl, "R8 forced hiz awake", hz, 1);
    cfg = '0;

    // R9 strap low tri-states
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    chk(!hz, "R9 awake not hiz", hz, 0);
    susp = 1'b1;
    cyc(1);
    chk(hz && !idl, "R9 strap low hiz", hz, 1);
    susp = 1'b0;
    cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule